// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block breaks a vector length known only at run time into pieces that a vector unit with a fixed maximum vector length can process. A single start pulse delivers the total element count. The block then offers a series of chunks on a valid/ready handshake. Each chunk carries the 1-based index of its first element and the value that the vector-length register should hold while that piece runs.

The piece whose size is not a full multiple comes out first. Every later piece is exactly the maximum length. When the total is an exact multiple of the maximum, no zero-length piece is produced. A one-cycle done pulse marks the end of the series. A zero total gives the done pulse and no chunk at all.

Top module: `strip_mine_seq`

## Requirements
- R1: A start pulse taken while the block is idle (chunk_valid and done both low) with a nonzero total_len raises chunk_valid on the next cycle, with chunk_low equal to 1.
- R2: When total_len modulo MAX_VL is nonzero, the first chunk has chunk_len equal to that remainder.
- R3: When total_len modulo MAX_VL is zero, the first chunk already has chunk_len equal to MAX_VL, and exactly total_len / MAX_VL chunks are issued; no zero-length chunk appears.
- R4: Every chunk after the first has chunk_len equal to MAX_VL. With a nonzero remainder, the number of chunks is the truncated quotient total_len / MAX_VL plus one.
- R5: The chunk_low of each later chunk equals the previous chunk_low plus the previous chunk_len.
- R6: While chunk_valid is high, chunk_len lies between 1 and MAX_VL inclusive.
- R7: While chunk_valid is high and chunk_ready is low, chunk_valid, chunk_low and chunk_len hold their values into the next cycle.
- R8: done is high for exactly one cycle, the cycle right after the last chunk is accepted, and chunk_valid is low in that cycle.
- R9: A start pulse with total_len equal to 0, taken while idle, raises done on the next cycle and issues no chunk.
- R10: A start pulse that arrives while a series is in progress has no effect on the chunks issued.
- R11: After reset, chunk_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a series when idle |
| total_len | input | LEN_W | Total element count, sampled on start |
| chunk_valid | output | 1 | A chunk is offered |
| chunk_ready | input | 1 | Consumer accepts the offered chunk |
| chunk_low | output | LEN_W | 1-based index of the chunk's first element |
| chunk_len | output | $clog2(MAX_VL+1) | Vector-length value for the chunk |
| done | output | 1 | One-cycle pulse after the last chunk is accepted |

## Verification
The checker watches several properties on every cycle: that the length stays in bounds, that a stalled chunk holds its value, that the index advances by the accepted length, that every chunk after the first is full length, and that done is a single cycle with no chunk beside it. It also checks the first response to a start pulse, for both zero and nonzero totals. Some properties only the bench's scenarios can show. These are that the first length is the true remainder, that the chunk count matches the quotient rule, that exact multiples produce no empty chunk, and that a start pulse during a series leaves the sequence unchanged. The bench shows them by comparing whole sequences against a model under several ready patterns.

// File: rtl/stripseq_pkg.sv
package stripseq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_ISSUE  = 2'd1,
        SQ_FINISH = 2'd2
    } sq_state_e;

    // Length of the leading chunk: the remainder, or a full chunk when the
    // remainder is zero (an empty leading chunk is never issued).
    function automatic int unsigned head_len(int unsigned total, int unsigned mvl);
        int unsigned rem;
        rem = total % mvl;
        return (rem == 0) ? mvl : rem;
    endfunction

endpackage

// File: rtl/stripseq_split.sv
module stripseq_split
    import stripseq_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int LEN_W  = 16,
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic [LEN_W-1:0] total,
    output logic [VL_W-1:0]  first_len,
    output logic             is_zero
);
    always_comb begin
        first_len = VL_W'(head_len(32'(total), 32'(MAX_VL)));
        is_zero   = (total == '0);
    end
endmodule

// File: rtl/stripseq_cursor.sv
module stripseq_cursor #(
    parameter int MAX_VL = 64,
    parameter int LEN_W  = 16,
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [LEN_W-1:0] load_total,
    input  logic [VL_W-1:0]  load_len,
    output logic [LEN_W-1:0] low,
    output logic [VL_W-1:0]  len,
    output logic             is_last
);
    localparam logic [VL_W-1:0] FULL = VL_W'(MAX_VL);

    logic [LEN_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low    <= '0;
            len    <= '0;
            left_q <= '0;
        end else if (load) begin
            low    <= LEN_W'(1);
            len    <= load_len;
            left_q <= load_total;
        end else if (step) begin
            low    <= low + LEN_W'(len);
            left_q <= left_q - LEN_W'(len);
            len    <= FULL;
        end
    end

    assign is_last = (left_q == LEN_W'(len));
endmodule

// File: rtl/stripseq_ctrl.sv
module stripseq_ctrl
    import stripseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic total_zero,
    input  logic ready,
    input  logic is_last,
    output logic load,
    output logic step,
    output logic valid,
    output logic done
);
    sq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (start) begin
                    if (total_zero) begin
                        state_d = SQ_FINISH;
                    end else begin
                        load    = 1'b1;
                        state_d = SQ_ISSUE;
                    end
                end
            end
            SQ_ISSUE: begin
                if (ready) begin
                    if (is_last) state_d = SQ_FINISH;
                    else         step    = 1'b1;
                end
            end
            SQ_FINISH: state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end

    assign valid = (state_q == SQ_ISSUE);
    assign done  = (state_q == SQ_FINISH);
endmodule

// File: rtl/strip_mine_seq.sv
module strip_mine_seq #(
    parameter int MAX_VL = 64,
    parameter int LEN_W  = 16,
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] total_len,
    output logic             chunk_valid,
    input  logic             chunk_ready,
    output logic [LEN_W-1:0] chunk_low,
    output logic [VL_W-1:0]  chunk_len,
    output logic             done
);
    logic [VL_W-1:0] head;
    logic            zero_total;
    logic            do_load;
    logic            do_step;
    logic            last_chunk;

    stripseq_split #(.MAX_VL(MAX_VL), .LEN_W(LEN_W)) u_split (
        .total     (total_len),
        .first_len (head),
        .is_zero   (zero_total)
    );

    stripseq_cursor #(.MAX_VL(MAX_VL), .LEN_W(LEN_W)) u_cursor (
        .clk        (clk),
        .rst        (rst),
        .load       (do_load),
        .step       (do_step),
        .load_total (total_len),
        .load_len   (head),
        .low        (chunk_low),
        .len        (chunk_len),
        .is_last    (last_chunk)
    );

    stripseq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .total_zero (zero_total),
        .ready      (chunk_ready),
        .is_last    (last_chunk),
        .load       (do_load),
        .step       (do_step),
        .valid      (chunk_valid),
        .done       (done)
    );
endmodule

// File: rtl/stripseq_checker.sv
module stripseq_checker #(
    parameter int MAX_VL = 64,
    parameter int LEN_W  = 16,
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [LEN_W-1:0] total_len,
    input logic             chunk_valid,
    input logic             chunk_ready,
    input logic [LEN_W-1:0] chunk_low,
    input logic [VL_W-1:0]  chunk_len,
    input logic             done
);
    localparam logic [VL_W-1:0] FULL = VL_W'(MAX_VL);

    a_r6_len_bound: assert property (@(posedge clk) disable iff (rst)
        chunk_valid |-> (chunk_len != '0) && (chunk_len <= FULL));

    a_r7_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (chunk_valid && !chunk_ready) |=> chunk_valid && $stable(chunk_low) && $stable(chunk_len));

    a_r5_low_advance: assert property (@(posedge clk) disable iff (rst)
        (chunk_valid && chunk_ready) |=>
            !chunk_valid || (chunk_low == $past(chunk_low) + LEN_W'($past(chunk_len))));

    a_r4_later_full: assert property (@(posedge clk) disable iff (rst)
        (chunk_valid && chunk_ready) |=> !chunk_valid || (chunk_len == FULL));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_alone: assert property (@(posedge clk) disable iff (rst)
        done |-> !chunk_valid);

    a_r1_first_low: assert property (@(posedge clk) disable iff (rst)
        (start && total_len != '0 && !chunk_valid && !done) |=> chunk_valid && (chunk_low == LEN_W'(1)));

    a_r9_zero_total: assert property (@(posedge clk) disable iff (rst)
        (start && total_len == '0 && !chunk_valid && !done) |=> done && !chunk_valid);

    a_r10_busy_start: assert property (@(posedge clk) disable iff (rst)
        (start && chunk_valid && !chunk_ready) |=> chunk_valid && $stable(chunk_low));
endmodule

bind strip_mine_seq stripseq_checker #(.MAX_VL(MAX_VL), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .total_len   (total_len),
    .chunk_valid (chunk_valid),
    .chunk_ready (chunk_ready),
    .chunk_low   (chunk_low),
    .chunk_len   (chunk_len),
    .done        (done)
);

// File: tb/strip_mine_seq_test.sv
module strip_mine_seq_test;
    localparam int MVL   = 64;
    localparam int LW    = 16;
    localparam int VW    = $clog2(MVL + 1);

    typedef struct {
        int    low;
        int    len;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [LW-1:0] total_len = '0;
    logic          chunk_valid;
    logic          chunk_ready = 1'b0;
    logic [LW-1:0] chunk_low;
    logic [VW-1:0] chunk_len;
    logic          done;

    int   n_tests = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   ready_mode = 0;
    int   done_seen = 0;
    bit   exp_done_next = 1'b0;
    bit   hold_pending = 1'b0;
    bit   mon_on = 1'b0;
    int   held_low;
    int   held_len;
    exp_t q[$];

    strip_mine_seq #(.MAX_VL(MVL), .LEN_W(LW)) uut (
        .clk(clk), .rst(rst), .start(start), .total_len(total_len),
        .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
        .chunk_low(chunk_low), .chunk_len(chunk_len), .done(done)
    );

    always #5 clk = ~clk;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: sets ready for the coming edge, then compares what is offered.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            check(1'b0, "WATCHDOG", "run expired", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
        if (mon_on) begin
            case (ready_mode)
                0:       chunk_ready = 1'b1;
                1:       chunk_ready = cyc[0];
                default: chunk_ready = (cyc % 3 == 0);
            endcase
            if (exp_done_next) begin
                check(done == 1'b1, "R8/R9", "done after last", int'(done), 1);
                check(chunk_valid == 1'b0, "R8", "valid beside done", int'(chunk_valid), 0);
                exp_done_next = 1'b0;
                done_seen++;
            end else if (done) begin
                check(1'b0, "R8", "unexpected done", 1, 0);
            end
            if (chunk_valid) begin
                if (hold_pending) begin
                    check(int'(chunk_low) == held_low, "R7", "held low", int'(chunk_low), held_low);
                    check(int'(chunk_len) == held_len, "R7", "held len", int'(chunk_len), held_len);
                end
                check(chunk_len >= 1 && int'(chunk_len) <= MVL, "R6", "len bound", int'(chunk_len), MVL);
                if (chunk_ready) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R4", "extra chunk", int'(chunk_low), 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(int'(chunk_low) == e.low, e.req, "chunk low", int'(chunk_low), e.low);
                        check(int'(chunk_len) == e.len, e.req, "chunk len", int'(chunk_len), e.len);
                        if (q.size() == 0) exp_done_next = 1'b1;
                    end
                    hold_pending = 1'b0;
                end else begin
                    hold_pending = 1'b1;
                    held_low = int'(chunk_low);
                    held_len = int'(chunk_len);
                end
            end else begin
                hold_pending = 1'b0;
            end
        end
    end

    // Driver: pushes the model's chunk list, pulses start, waits for done.
    task automatic run_case(int n, int mode, bit busy_start);
        int low;
        int rem;
        int seen0;
        @(negedge clk); #2;
        ready_mode = mode;
        seen0 = done_seen;
        rem = n % MVL;
        low = 1;
        if (rem != 0) begin
            q.push_back('{low: 1, len: rem, req: "R2"});
            low += rem;
        end
        for (int j = 0; j < n / MVL; j++) begin
            q.push_back('{low: low, len: MVL,
                          req: (j == 0 && rem == 0) ? "R3" : ((j == 0) ? "R1" : "R5")});
            low += MVL;
        end
        if (q.size() > 0) q[0].req = (rem != 0) ? "R2" : "R3";
        start = 1'b1;
        total_len = LW'(n);
        if (n == 0) exp_done_next = 1'b1;
        @(negedge clk); #2;
        start = 1'b0;
        if (n != 0) check(chunk_valid == 1'b1 && chunk_low == LW'(1), "R1", "first chunk", int'(chunk_low), 1);
        if (busy_start) begin
            repeat (2) @(negedge clk);
            #2;
            check(chunk_valid == 1'b1, "R10", "busy at extra start", int'(chunk_valid), 1);
            start = 1'b1;
            total_len = LW'(5);
            @(negedge clk); #2;
            start = 1'b0;
        end
        for (int t = 0; t < 2000 && done_seen == seen0; t++) @(negedge clk);
        #2;
        check(done_seen == seen0 + 1, "R8", "done count", done_seen - seen0, 1);
        check(q.size() == 0, "R4", "chunks left", q.size(), 0);
        q.delete();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        check(chunk_valid == 1'b0, "R11", "valid after reset", int'(chunk_valid), 0);
        check(done == 1'b0, "R11", "done after reset", int'(done), 0);
        mon_on = 1'b1;
        run_case(0, 0, 1'b0);      // R9
        run_case(1, 0, 1'b0);      // R2
        run_case(63, 1, 1'b0);     // R2
        run_case(64, 0, 1'b0);     // R3
        run_case(65, 2, 1'b0);     // R2 R4 R5
        run_case(128, 1, 1'b0);    // R3 R4
        run_case(200, 2, 1'b0);    // R4 R5 R7
        run_case(130, 2, 1'b1);    // R10
        run_case(0, 1, 1'b0);      // R9 again
        run_case(300, 0, 1'b0);    // R4 R5
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule